// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic-Logic Unit with Accumulator Pair and Status Flags

This block is a clocked 16-bit arithmetic-logic unit. A 5-bit function code selects one of up to 32 operations on two 16-bit operands. The operations are bitwise logic, Gray-code conversion both ways, add and subtract with and without a carry/borrow input, compare, single-bit shifts and rotates that pass through the carry flag, an unsigned 16x16 multiply and an unsigned 16-bit divide. The carry input of the chained operations is the carry flag left by the previous operation. Results are held in a low accumulator. A high accumulator receives the upper half of a product or the remainder of a division.

A one-cycle `start` strobe commits an operation: the accumulators and the seven status flags load on the rising clock edge where `start` is high. They hold their values at every other edge. The flags are carry, signed overflow, sign, zero, nibble (auxiliary) carry, even parity and divide-by-zero. A division by zero changes only the divide-by-zero flag. Function codes with no operation assigned leave all state untouched.

Top module: `alu16_core`

## Requirements
- R1: While `rst_n` is low, both accumulators and all seven flags are cleared to zero at the clock edge.
- R2: At an edge where `start` is low, the accumulators and flags keep their values, whatever the function code and operands are.
- R3: Codes 0..7 (0 AND, 1 OR, 2 XOR, 3 NOT A, 4 NAND, 5 NOR, 6 XNOR, 7 pass A) write their bitwise result to the low accumulator and clear carry, overflow, nibble carry and divide-by-zero.
- R4: Code 8 (add) writes A+B and code 9 (add with carry) writes A+B+C. The carry flag takes the carry out of bit 15, the nibble flag takes the carry out of bit 3, and overflow is set when A and B have equal signs and the result sign differs from them.
- R5: Code 10 (subtract) writes A-B and code 11 (subtract with borrow) writes A-B-C. The carry flag is set on a borrow out of bit 15, the nibble flag on a borrow out of bit 3, and overflow when A and B differ in sign and the result sign differs from A.
- R6: Code 12 (compare) sets the flags exactly as code 10 would and leaves both accumulators unchanged.
- R7: Code 14 (multiply) writes the unsigned 32-bit product: its low half to the low accumulator and its high half to the high accumulator. Carry and overflow are both set when the high half is nonzero, and the nibble flag is cleared.
- R8: Code 15 (divide) with a nonzero B writes the unsigned quotient A/B to the low accumulator and the remainder to the high accumulator. It clears carry, overflow, nibble carry and divide-by-zero.
- R9: Code 15 with B equal to zero sets the divide-by-zero flag and leaves both accumulators and all other flags unchanged. Any later operation on an assigned code other than a zero-divisor divide clears the divide-by-zero flag.
- R10: Code 16 shifts A right and code 17 shifts A left by one bit, filling with zero. The carry flag takes the bit shifted out, and overflow and nibble carry are cleared.
- R11: Code 18 rotates right through carry (old carry enters bit 15, bit 0 goes to carry). Code 19 rotates left through carry (old carry enters bit 0, bit 15 goes to carry).
- R12: Code 20 writes the Gray code of A (A xor A>>1). Code 21 converts A from Gray code back to binary (each result bit is the xor of A's bits at and above it). Both follow the flag rule of R3.
- R13: After every operation that sets flags, sign equals bit 15 of the result, zero is set when all 16 result bits are zero, and parity is set when the result has an even number of ones. The result is the value written to the low accumulator, or the difference for compare. The high accumulator changes only for codes 14 and 15.
- R14: Codes 13 and 22..31 change neither accumulator nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Commit strobe for the current function code |
| func_sel | input | 5 | Function code |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B (divisor for division) |
| acc_lo | output | 16 | Low accumulator |
| acc_hi | output | 16 | High accumulator (product high half or remainder) |
| flag_c | output | 1 | Carry / borrow flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Nibble (auxiliary) carry flag |
| flag_p | output | 1 | Even parity flag |
| flag_dz | output | 1 | Divide-by-zero flag |

## Verification
Two things meet in one edge whenever chained operations run back to back. The carry flag is read as the carry-in of add-with-carry, subtract-with-borrow or a rotate, and the same edge overwrites it with that operation's new carry. The bench provokes this with directed chains of consecutive strobes (add producing a carry, then add with carry, then rotates) and with a long random sequence that strobes in every cycle. A bench model judges each result; it carries its own copy of the flag from step to step. Zero-divisor divides are placed between other operations to check that the flag is kept and then cleared.

// File: rtl/alu16_pkg.sv
// Package: shared function codes, flag layout and operation grouping for
// the 16-bit ALU. Assumes a 5-bit function code; unlisted codes are idle.
package alu16_pkg;

    localparam int SEL_W = 5;

    typedef enum logic [SEL_W-1:0] {
        OP_AND    = 5'd0,
        OP_OR     = 5'd1,
        OP_XOR    = 5'd2,
        OP_NOTA   = 5'd3,
        OP_NAND   = 5'd4,
        OP_NOR    = 5'd5,
        OP_XNOR   = 5'd6,
        OP_PASSA  = 5'd7,
        OP_ADD    = 5'd8,
        OP_ADC    = 5'd9,
        OP_SUB    = 5'd10,
        OP_SBB    = 5'd11,
        OP_CMP    = 5'd12,
        OP_MUL    = 5'd14,
        OP_DIV    = 5'd15,
        OP_SHR    = 5'd16,
        OP_SHL    = 5'd17,
        OP_ROR    = 5'd18,
        OP_ROL    = 5'd19,
        OP_GRAY   = 5'd20,
        OP_UNGRAY = 5'd21
    } alu_op_e;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_LOGIC,
        GRP_ARITH,
        GRP_SHIFT,
        GRP_MUL,
        GRP_DIV
    } alu_grp_e;

    typedef struct packed {
        logic dz;
        logic p;
        logic ac;
        logic z;
        logic s;
        logic v;
        logic c;
    } alu_flags_t;

    // Maps a function code onto the execution unit that serves it.
    function automatic alu_grp_e op_group(input logic [SEL_W-1:0] code);
        case (code)
            OP_AND, OP_OR, OP_XOR, OP_NOTA, OP_NAND, OP_NOR, OP_XNOR,
            OP_PASSA, OP_GRAY, OP_UNGRAY:      return GRP_LOGIC;
            OP_ADD, OP_ADC, OP_SUB, OP_SBB,
            OP_CMP:                            return GRP_ARITH;
            OP_SHR, OP_SHL, OP_ROR, OP_ROL:    return GRP_SHIFT;
            OP_MUL:                            return GRP_MUL;
            OP_DIV:                            return GRP_DIV;
            default:                           return GRP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alu16_logic.sv
// Module: bitwise logic and Gray-code conversion unit.
// Purely combinational; assumes the caller only uses the result for
// codes in the logic group.
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [SEL_W-1:0] func_sel,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    output logic [W-1:0]     res
);

    logic [W-1:0] ungray;

    // Gray-to-binary: prefix xor running from the top bit downward.
    always_comb begin
        logic acc_bit;
        acc_bit = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc_bit   = acc_bit ^ opa[i];
            ungray[i] = acc_bit;
        end
    end

    // Select the logic result for the requested code.
    always_comb begin
        case (func_sel)
            OP_AND:    res = opa & opb;
            OP_OR:     res = opa | opb;
            OP_XOR:    res = opa ^ opb;
            OP_NOTA:   res = ~opa;
            OP_NAND:   res = ~(opa & opb);
            OP_NOR:    res = ~(opa | opb);
            OP_XNOR:   res = ~(opa ^ opb);
            OP_PASSA:  res = opa;
            OP_GRAY:   res = opa ^ (opa >> 1);
            OP_UNGRAY: res = ungray;
            default:   res = '0;
        endcase
    end

endmodule

// File: rtl/alu16_addsub.sv
// Module: adder/subtractor with carry-in, carry, nibble carry and signed
// overflow outputs. Subtraction is A + ~B + ~borrow; carry out is
// reported as a borrow for subtraction.
module alu16_addsub #(
    parameter int W   = 16,
    parameter int NIB = 4
) (
    input  logic         is_sub,
    input  logic         use_cin,
    input  logic         cin,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         v_out,
    output logic         ac_out
);

    logic [W-1:0]   b_eff;
    logic           cin_eff;
    logic [W:0]     sum;
    logic [NIB:0]   nsum;

    // Form the effective second operand and carry for add or subtract.
    always_comb begin
        b_eff   = is_sub ? ~opb : opb;
        cin_eff = is_sub ? ~(use_cin & cin) : (use_cin & cin);
    end

    // Full-width and low-nibble sums.
    always_comb begin
        sum  = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
        nsum = {1'b0, opa[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, cin_eff};
    end

    // Result and flag outputs; carries invert to borrows when subtracting.
    always_comb begin
        res    = sum[W-1:0];
        c_out  = is_sub ? ~sum[W] : sum[W];
        ac_out = is_sub ? ~nsum[NIB] : nsum[NIB];
        v_out  = (opa[W-1] == b_eff[W-1]) && (sum[W-1] != opa[W-1]);
    end

endmodule

// File: rtl/alu16_shift.sv
// Module: one-bit shift and rotate unit whose carry path runs through the
// stored carry flag. Assumes only shift-group codes use its outputs.
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [SEL_W-1:0] func_sel,
    input  logic [W-1:0]     opa,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             c_out
);

    // Pick fill bit and outgoing bit for each direction.
    always_comb begin
        case (func_sel)
            OP_SHR: begin
                res   = {1'b0, opa[W-1:1]};
                c_out = opa[0];
            end
            OP_SHL: begin
                res   = {opa[W-2:0], 1'b0};
                c_out = opa[W-1];
            end
            OP_ROR: begin
                res   = {cin, opa[W-1:1]};
                c_out = opa[0];
            end
            OP_ROL: begin
                res   = {opa[W-2:0], cin};
                c_out = opa[W-1];
            end
            default: begin
                res   = opa;
                c_out = cin;
            end
        endcase
    end

endmodule

// File: rtl/alu16_muldiv.sv
// Module: unsigned multiplier and restoring divider, both combinational.
// The divider output is meaningless for a zero divisor; the caller must
// guard that case.
module alu16_muldiv #(
    parameter int W = 16
) (
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [2*W-1:0] prod,
    output logic [W-1:0]   quo,
    output logic [W-1:0]   rem
);

    // Full-width unsigned product.
    always_comb begin
        prod = {{W{1'b0}}, opa} * {{W{1'b0}}, opb};
    end

    // Restoring division, one quotient bit per unrolled step, MSB first.
    always_comb begin
        logic [W:0] part;
        part = '0;
        quo  = '0;
        for (int i = W - 1; i >= 0; i--) begin
            part = {part[W-1:0], opa[i]};
            if (part >= {1'b0, opb}) begin
                part   = part - {1'b0, opb};
                quo[i] = 1'b1;
            end
        end
        rem = part[W-1:0];
    end

endmodule

// File: rtl/alu16_core.sv
// Module: top of the 16-bit ALU. Holds the low/high accumulators and the
// status flags, and loads them on a clock edge with start high.
// Assumes synchronous active-low reset and one operation per strobe.
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W   = 16,
    parameter int NIB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] func_sel,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    output logic [W-1:0]     acc_lo,
    output logic [W-1:0]     acc_hi,
    output logic             flag_c,
    output logic             flag_v,
    output logic             flag_s,
    output logic             flag_z,
    output logic             flag_ac,
    output logic             flag_p,
    output logic             flag_dz
);

    alu_grp_e     grp;
    alu_flags_t   flags_q;
    alu_flags_t   flags_d;
    logic [W-1:0] lo_q, hi_q, lo_d, hi_d;

    logic [W-1:0]   logic_res;
    logic [W-1:0]   as_res;
    logic           as_c, as_v, as_ac;
    logic           as_sub, as_cin_en;
    logic [W-1:0]   sh_res;
    logic           sh_c;
    logic [2*W-1:0] md_prod;
    logic [W-1:0]   md_quo, md_rem;

    // Decode the operation group and the adder controls.
    always_comb begin
        grp       = op_group(func_sel);
        as_sub    = (func_sel == OP_SUB) || (func_sel == OP_SBB) || (func_sel == OP_CMP);
        as_cin_en = (func_sel == OP_ADC) || (func_sel == OP_SBB);
    end

    alu16_logic #(.W(W)) u_logic (
        .func_sel (func_sel),
        .opa      (opnd_a),
        .opb      (opnd_b),
        .res      (logic_res)
    );

    alu16_addsub #(.W(W), .NIB(NIB)) u_addsub (
        .is_sub   (as_sub),
        .use_cin  (as_cin_en),
        .cin      (flags_q.c),
        .opa      (opnd_a),
        .opb      (opnd_b),
        .res      (as_res),
        .c_out    (as_c),
        .v_out    (as_v),
        .ac_out   (as_ac)
    );

    alu16_shift #(.W(W)) u_shift (
        .func_sel (func_sel),
        .opa      (opnd_a),
        .cin      (flags_q.c),
        .res      (sh_res),
        .c_out    (sh_c)
    );

    alu16_muldiv #(.W(W)) u_muldiv (
        .opa      (opnd_a),
        .opb      (opnd_b),
        .prod     (md_prod),
        .quo      (md_quo),
        .rem      (md_rem)
    );

    // Compute next accumulator and flag values for the selected group.
    always_comb begin
        logic [W-1:0] res;
        logic         szp_en;
        lo_d    = lo_q;
        hi_d    = hi_q;
        flags_d = flags_q;
        res     = '0;
        szp_en  = 1'b0;
        case (grp)
            GRP_LOGIC: begin
                res        = logic_res;
                lo_d       = res;
                flags_d.c  = 1'b0;
                flags_d.v  = 1'b0;
                flags_d.ac = 1'b0;
                flags_d.dz = 1'b0;
                szp_en     = 1'b1;
            end
            GRP_ARITH: begin
                res        = as_res;
                if (func_sel != OP_CMP) begin
                    lo_d = res;
                end
                flags_d.c  = as_c;
                flags_d.v  = as_v;
                flags_d.ac = as_ac;
                flags_d.dz = 1'b0;
                szp_en     = 1'b1;
            end
            GRP_SHIFT: begin
                res        = sh_res;
                lo_d       = res;
                flags_d.c  = sh_c;
                flags_d.v  = 1'b0;
                flags_d.ac = 1'b0;
                flags_d.dz = 1'b0;
                szp_en     = 1'b1;
            end
            GRP_MUL: begin
                res        = md_prod[W-1:0];
                lo_d       = res;
                hi_d       = md_prod[2*W-1:W];
                flags_d.c  = |md_prod[2*W-1:W];
                flags_d.v  = |md_prod[2*W-1:W];
                flags_d.ac = 1'b0;
                flags_d.dz = 1'b0;
                szp_en     = 1'b1;
            end
            GRP_DIV: begin
                if (opnd_b == '0) begin
                    flags_d.dz = 1'b1;
                end else begin
                    res        = md_quo;
                    lo_d       = res;
                    hi_d       = md_rem;
                    flags_d.c  = 1'b0;
                    flags_d.v  = 1'b0;
                    flags_d.ac = 1'b0;
                    flags_d.dz = 1'b0;
                    szp_en     = 1'b1;
                end
            end
            default: begin
                szp_en = 1'b0;
            end
        endcase
        if (szp_en) begin
            flags_d.s = res[W-1];
            flags_d.z = (res == '0);
            flags_d.p = ~^res;
        end
    end

    // State registers: clear on reset, load only on a start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            flags_q <= '0;
        end else if (start) begin
            lo_q    <= lo_d;
            hi_q    <= hi_d;
            flags_q <= flags_d;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        acc_lo  = lo_q;
        acc_hi  = hi_q;
        flag_c  = flags_q.c;
        flag_v  = flags_q.v;
        flag_s  = flags_q.s;
        flag_z  = flags_q.z;
        flag_ac = flags_q.ac;
        flag_p  = flags_q.p;
        flag_dz = flags_q.dz;
    end

endmodule

// File: rtl/alu16_core_chk.sv
// Module: property checker for alu16_core, attached through bind.
// Observes ports only; every property is disabled while reset is low.
module alu16_core_chk
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [SEL_W-1:0] func_sel,
    input logic [W-1:0]     opnd_a,
    input logic [W-1:0]     opnd_b,
    input logic [W-1:0]     acc_lo,
    input logic [W-1:0]     acc_hi,
    input logic             flag_c,
    input logic             flag_v,
    input logic             flag_s,
    input logic             flag_z,
    input logic             flag_ac,
    input logic             flag_p,
    input logic             flag_dz
);

    logic [6:0] flag_vec;
    logic       grp_none, grp_logic, writes_lo, hi_free;

    // Gather the flags and classify the presented code.
    always_comb begin
        flag_vec  = {flag_dz, flag_p, flag_ac, flag_z, flag_s, flag_v, flag_c};
        grp_none  = (op_group(func_sel) == GRP_NONE);
        grp_logic = (op_group(func_sel) == GRP_LOGIC);
        hi_free   = (func_sel != OP_MUL) && (func_sel != OP_DIV);
        writes_lo = !grp_none && (func_sel != OP_CMP) &&
                    !((func_sel == OP_DIV) && (opnd_b == '0));
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(acc_lo) && $stable(acc_hi) && $stable(flag_vec)); // R2

    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start && grp_logic |=> !flag_c && !flag_v && !flag_ac && !flag_dz); // R3

    AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        start && (func_sel == OP_PASSA) |=> acc_lo == $past(opnd_a)); // R3

    AST_CMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        start && (func_sel == OP_CMP) |=> $stable(acc_lo) && $stable(acc_hi)); // R6

    AST_MUL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        start && (func_sel == OP_MUL) |=> (flag_c == (acc_hi != '0)) && (flag_v == flag_c)); // R7

    AST_DIV_OK: assert property (@(posedge clk) disable iff (!rst_n)
        start && (func_sel == OP_DIV) && (opnd_b != '0) |=> !flag_dz && (acc_hi < $past(opnd_b))); // R8

    AST_DZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        start && (func_sel == OP_DIV) && (opnd_b == '0) |=>
        flag_dz && $stable(acc_lo) && $stable(acc_hi) && $stable(flag_vec[5:0])); // R9

    AST_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        start && hi_free |=> $stable(acc_hi)); // R13

    AST_SZP: assert property (@(posedge clk) disable iff (!rst_n)
        start && writes_lo |=>
        (flag_s == acc_lo[W-1]) && (flag_z == (acc_lo == '0)) && (flag_p == ~^acc_lo)); // R13

    AST_UNUSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        start && grp_none |=> $stable(acc_lo) && $stable(acc_hi) && $stable(flag_vec)); // R14

endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .func_sel (func_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .acc_lo   (acc_lo),
    .acc_hi   (acc_hi),
    .flag_c   (flag_c),
    .flag_v   (flag_v),
    .flag_s   (flag_s),
    .flag_z   (flag_z),
    .flag_ac  (flag_ac),
    .flag_p   (flag_p),
    .flag_dz  (flag_dz)
);

// File: tb/alu16_core_tb.sv
// Bench for alu16_core: directed corners followed by seeded random
// operations, all compared against a behavioural model kept in the bench.
module alu16_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  func_sel = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] acc_lo, acc_hi;
    logic        flag_c, flag_v, flag_s, flag_z, flag_ac, flag_p, flag_dz;

    logic [15:0] m_lo = '0, m_hi = '0;
    logic        m_c = 0, m_v = 0, m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_dz = 0;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    alu16_core u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .func_sel(func_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
        .flag_c(flag_c), .flag_v(flag_v), .flag_s(flag_s), .flag_z(flag_z),
        .flag_ac(flag_ac), .flag_p(flag_p), .flag_dz(flag_dz)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string req_of(input logic [4:0] f, input logic [15:0] b);
        if (f <= 5'd7 || f == 5'd20 || f == 5'd21) return (f >= 5'd20) ? "R12" : "R3";
        case (f)
            5'd8, 5'd9:   return "R4";
            5'd10, 5'd11: return "R5";
            5'd12:        return "R6";
            5'd14:        return "R7";
            5'd15:        return (b == 16'd0) ? "R9" : "R8";
            5'd16, 5'd17: return "R10";
            5'd18, 5'd19: return "R11";
            default:      return "R14";
        endcase
    endfunction

    // Behavioural model of one committed operation.
    task automatic model(input logic [4:0] f, input logic [15:0] a, input logic [15:0] b);
        logic [31:0] t;
        logic [15:0] r;
        logic        cin, wr, szp;
        cin = m_c; wr = 1; szp = 1; r = '0;
        case (f)
            5'd0:  r = a & b;
            5'd1:  r = a | b;
            5'd2:  r = a ^ b;
            5'd3:  r = ~a;
            5'd4:  r = ~(a & b);
            5'd5:  r = ~(a | b);
            5'd6:  r = ~(a ^ b);
            5'd7:  r = a;
            5'd20: r = a ^ (a >> 1);
            5'd21: begin
                r = a;
                for (int k = 1; k < 16; k++) r = r ^ (a >> k);
            end
            default: ;
        endcase
        if (f <= 5'd7 || f == 5'd20 || f == 5'd21) begin
            m_c = 0; m_v = 0; m_ac = 0; m_dz = 0;
        end else if (f == 5'd8 || f == 5'd9) begin
            t = 32'(a) + 32'(b) + ((f == 5'd9) ? 32'(cin) : 32'd0);
            r = t[15:0];
            m_c  = t > 32'hFFFF;
            m_ac = (32'(a & 16'hF) + 32'(b & 16'hF) + ((f == 5'd9) ? 32'(cin) : 32'd0)) > 32'd15;
            m_v  = (a[15] == b[15]) && (r[15] != a[15]);
            m_dz = 0;
        end else if (f == 5'd10 || f == 5'd11 || f == 5'd12) begin
            t = (f == 5'd11) ? 32'(cin) : 32'd0;
            r = a - b - t[15:0];
            m_c  = 32'(a) < 32'(b) + t;
            m_ac = 32'(a & 16'hF) < 32'(b & 16'hF) + t;
            m_v  = (a[15] != b[15]) && (r[15] != a[15]);
            m_dz = 0;
            if (f == 5'd12) wr = 0;
        end else if (f == 5'd14) begin
            t = 32'(a) * 32'(b);
            r = t[15:0]; m_hi = t[31:16];
            m_c = (t[31:16] != 0); m_v = m_c; m_ac = 0; m_dz = 0;
        end else if (f == 5'd15) begin
            if (b == 0) begin
                m_dz = 1; wr = 0; szp = 0;
            end else begin
                r = a / b; m_hi = a % b;
                m_c = 0; m_v = 0; m_ac = 0; m_dz = 0;
            end
        end else if (f >= 5'd16 && f <= 5'd19) begin
            case (f)
                5'd16:   begin r = a >> 1;         m_c = a[0];  end
                5'd17:   begin r = a << 1;         m_c = a[15]; end
                5'd18:   begin r = {cin, a[15:1]}; m_c = a[0];  end
                default: begin r = {a[14:0], cin}; m_c = a[15]; end
            endcase
            m_v = 0; m_ac = 0; m_dz = 0;
        end else begin
            wr = 0; szp = 0;
        end
        if (wr) m_lo = r;
        if (szp) begin
            m_s = r[15];
            m_z = (r == 0);
            m_p = ($countones(r) % 2) == 0;
        end
    endtask

    task automatic do_op(input logic [4:0] f, input logic [15:0] a, input logic [15:0] b);
        string tag;
        @(negedge clk);
        func_sel = f; opnd_a = a; opnd_b = b; start = 1'b1;
        model(f, a, b);
        tag = req_of(f, b);
        @(negedge clk);
        start = 1'b0;
        chk(tag, {acc_hi, acc_lo}, {m_hi, m_lo});
        chk(tag, {28'd0, flag_c, flag_v, flag_ac, flag_dz}, {28'd0, m_c, m_v, m_ac, m_dz});
        chk("R13", {29'd0, flag_s, flag_z, flag_p}, {29'd0, m_s, m_z, m_p});
    endtask

    task automatic idle_step(input logic [4:0] f, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        func_sel = f; opnd_a = a; opnd_b = b; start = 1'b0;
        @(negedge clk);
        chk("R2", {acc_hi, acc_lo}, {m_hi, m_lo});
        chk("R2", {25'd0, flag_c, flag_v, flag_s, flag_z, flag_ac, flag_p, flag_dz},
                  {25'd0, m_c, m_v, m_s, m_z, m_ac, m_p, m_dz});
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state, with a start strobe held during reset
        start = 1'b1; func_sel = 5'd7; opnd_a = 16'hBEEF;
        @(negedge clk);
        chk("R1", {acc_hi, acc_lo}, 32'd0);
        chk("R1", {25'd0, flag_c, flag_v, flag_s, flag_z, flag_ac, flag_p, flag_dz}, 32'd0);
        start = 1'b0; rst_n = 1'b1;

        idle_step(5'd7, 16'h1234, 16'h0);          // R2
        do_op(5'd0, 16'hF0F0, 16'hFF00);           // R3
        do_op(5'd1, 16'h0F00, 16'h00F0);
        do_op(5'd2, 16'hAAAA, 16'hAAAA);           // zero result
        do_op(5'd3, 16'h00FF, 16'h0);
        do_op(5'd4, 16'hFFFF, 16'h0F0F);
        do_op(5'd5, 16'h1000, 16'h0001);
        do_op(5'd6, 16'h1234, 16'h4321);
        do_op(5'd7, 16'h8001, 16'h0);
        do_op(5'd8, 16'h7FFF, 16'h0001);           // R4: overflow and nibble carry
        do_op(5'd8, 16'hFFFF, 16'h0001);           // carry, zero
        do_op(5'd9, 16'h0001, 16'h0001);           // add with carry set
        do_op(5'd9, 16'h8000, 16'h8000);           // carry and overflow
        do_op(5'd10, 16'h0000, 16'h0001);          // R5: borrow
        do_op(5'd10, 16'h8000, 16'h0001);          // signed overflow
        do_op(5'd11, 16'h0005, 16'h0004);          // borrow in with no borrow set
        do_op(5'd10, 16'h0000, 16'h0001);
        do_op(5'd11, 16'h0010, 16'h000F);          // borrow in consumed
        do_op(5'd12, 16'h1234, 16'h1234);          // R6
        do_op(5'd12, 16'h0001, 16'h0002);
        do_op(5'd14, 16'hFFFF, 16'hFFFF);          // R7
        do_op(5'd14, 16'h0010, 16'h0020);
        do_op(5'd15, 16'd100, 16'd7);              // R8
        do_op(5'd15, 16'hFFFF, 16'h0001);
        do_op(5'd15, 16'h1234, 16'h0000);          // R9
        idle_step(5'd15, 16'h1, 16'h0);
        do_op(5'd15, 16'h0003, 16'h0009);          // quotient zero, clears dz
        do_op(5'd15, 16'h4321, 16'h0000);
        do_op(5'd2, 16'h0001, 16'h0003);           // dz cleared by logic op
        do_op(5'd16, 16'h8001, 16'h0);             // R10
        do_op(5'd17, 16'h8001, 16'h0);
        do_op(5'd18, 16'h0002, 16'h0);             // R11, carry from previous
        do_op(5'd19, 16'h8000, 16'h0);
        do_op(5'd18, 16'h0001, 16'h0);
        do_op(5'd19, 16'h0000, 16'h0);
        do_op(5'd20, 16'hB5A3, 16'h0);             // R12
        do_op(5'd21, 16'hEE7A, 16'h0);
        do_op(5'd13, 16'h5555, 16'h1111);          // R14
        do_op(5'd22, 16'hFFFF, 16'h0);
        do_op(5'd31, 16'h0, 16'h0);

        for (int n = 0; n < 600; n++) begin
            logic [4:0]  f;
            logic [15:0] a, b;
            f = 5'($urandom % 32);
            a = 16'($urandom);
            b = (($urandom % 8) == 0) ? 16'd0 : 16'($urandom);
            if (($urandom % 10) == 0) idle_step(f, a, b);
            else do_op(f, a, b);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule